// File: doc/BRIEF.md
# Scoreboard Youngest-Producer Hazard Finder

This combinational block looks at a circular instruction scoreboard and tells the issue stage whether any instruction still in flight will write the register that a new source operand reads. If one or more do, it returns the slot of the most recently allocated writer. A consumer can then wait on that slot, or take its value from it, without being held up by older writers of the same register.

Slots are allocated at the issue pointer, which then advances and wraps. The most recent writer is therefore the first match found when walking downwards from the slot just below the pointer. The block does not walk the buffer. It compares every slot at once and splits the match vector at the pointer. It takes the highest matching index in each part. A match below the pointer wins over one at or above it.

Top module: `sb_youngest_producer`

## Requirements
- R1: A slot counts as a writer only when its valid bit is 1, its destination index equals the operand's register index, and its file flag (0 = integer, 1 = floating point) equals the operand's flag.
- R2: An integer operand (flag 0) naming register 0 never reports a hazard. A floating-point operand naming register 0 is compared like any other register.
- R3: `hazard_o` is 1 exactly when at least one slot is a writer under R1 and R2. The outputs follow the inputs within the same cycle, with no storage.
- R4: When a writer exists at a slot index lower than `issue_ptr_i`, `hazard_idx_o` is the highest such index, even if writers also exist at or above the pointer.
- R5: When no writer is below the pointer, `hazard_idx_o` is the highest writer index at or above `issue_ptr_i`.
- R6: When no slot is a writer, `hazard_o` is 0 and `hazard_idx_o` is 0.
- R7: With `issue_ptr_i` = 0, every slot falls in the upper part, and the highest matching index is reported.
- R8: With `issue_ptr_i` = N-1, only slot N-1 lies in the upper part. It is reported only when no lower slot matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | N | Per-slot in-flight bit |
| dest_idx_i | input | N*RW | Destination register index of each slot; slot k in bits k*RW +: RW |
| dest_fp_i | input | N | Per-slot file flag, 1 = floating point |
| issue_ptr_i | input | $clog2(N) | Slot that the next allocation will take |
| src_idx_i | input | RW | Register index read by the operand |
| src_fp_i | input | 1 | Operand file flag, 1 = floating point |
| hazard_o | output | 1 | A writer of the operand is in flight |
| hazard_idx_o | output | $clog2(N) | Slot of the most recent writer, 0 when none |

## Verification
Directed patterns place writers only below the pointer, only at or above it, and on both sides of it. This separates the lower-part priority from the plain highest-index choice. The pointer is set to 0 and to N-1 so that an off-by-one in the split shows up at both edges. Other patterns use slots that differ from the operand only in the valid bit, or only in the file flag, or that name integer register 0, each of which would create a false hazard if that qualifier were dropped. Random slot contents are then compared against a reference that walks the slots backwards from the pointer, so any disagreement about age order is caught.

// File: rtl/sbyp_pkg.sv
// Shared definitions for the youngest-producer finder.
// Assumes: file flag is a single bit, integer register 0 is hard-wired zero.
package sbyp_pkg;
    typedef enum logic {
        RF_INT = 1'b0,
        RF_FP  = 1'b1
    } rf_kind_e;
endpackage

// File: rtl/sbyp_match.sv
// Parallel comparator: flags each scoreboard slot whose pending write
// targets the operand register in the same register file.
// Assumes: destination fields are packed slot-major, RW bits each.
module sbyp_match #(
    parameter int N  = 8,
    parameter int RW = 5
) (
    input  logic [N-1:0]    valid_i,
    input  logic [N*RW-1:0] dest_idx_i,
    input  logic [N-1:0]    dest_fp_i,
    input  logic [RW-1:0]   src_idx_i,
    input  logic            src_fp_i,
    output logic [N-1:0]    match_o
);
    import sbyp_pkg::*;

    logic     src_is_zero_int;
    rf_kind_e src_kind;

    // Decode the operand file and spot the hard-wired integer zero register.
    always_comb begin
        src_kind        = rf_kind_e'(src_fp_i);
        src_is_zero_int = (src_kind == RF_INT) && (src_idx_i == '0);
    end

    for (genvar k = 0; k < N; k++) begin : g_slot
        rf_kind_e slot_kind;
        // One comparator per slot: valid, same file, same register.
        always_comb begin
            slot_kind  = rf_kind_e'(dest_fp_i[k]);
            match_o[k] = valid_i[k]
                       && (slot_kind == src_kind)
                       && (dest_idx_i[k*RW +: RW] == src_idx_i)
                       && !src_is_zero_int;
        end
    end
endmodule

// File: rtl/sbyp_last_set.sv
// Finds the highest set bit of a vector and reports whether any bit is set.
// Assumes: PW bits are enough to encode N-1.
module sbyp_last_set #(
    parameter int N  = 8,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [PW-1:0] idx_o
);
    // Upward scan: a later set bit overrides an earlier one.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/sb_youngest_producer.sv
// Youngest-producer hazard finder for a circular scoreboard.
// Splits the slot matches at the issue pointer, takes the highest match
// on each side, and prefers the side below the pointer (more recent).
// Assumes: slots are allocated at issue_ptr_i, which advances with wrap;
// purely combinational, no clock or reset.
module sb_youngest_producer #(
    parameter int N  = 8,
    parameter int RW = 5,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]    valid_i,
    input  logic [N*RW-1:0] dest_idx_i,
    input  logic [N-1:0]    dest_fp_i,
    input  logic [PW-1:0]   issue_ptr_i,
    input  logic [RW-1:0]   src_idx_i,
    input  logic            src_fp_i,
    output logic            hazard_o,
    output logic [PW-1:0]   hazard_idx_o
);
    logic [N-1:0]  match;
    logic [N-1:0]  below_mask;
    logic [N-1:0]  lo_match;
    logic [N-1:0]  hi_match;
    logic          lo_found;
    logic          hi_found;
    logic [PW-1:0] lo_idx;
    logic [PW-1:0] hi_idx;

    sbyp_match #(.N(N), .RW(RW)) u_match (
        .valid_i    (valid_i),
        .dest_idx_i (dest_idx_i),
        .dest_fp_i  (dest_fp_i),
        .src_idx_i  (src_idx_i),
        .src_fp_i   (src_fp_i),
        .match_o    (match)
    );

    for (genvar k = 0; k < N; k++) begin : g_split
        // Mark slots strictly below the issue pointer.
        always_comb below_mask[k] = (PW'(k) < issue_ptr_i);
    end

    // Partition the match vector at the pointer.
    always_comb begin
        lo_match = match & below_mask;
        hi_match = match & ~below_mask;
    end

    sbyp_last_set #(.N(N), .PW(PW)) u_lo (
        .vec_i   (lo_match),
        .found_o (lo_found),
        .idx_o   (lo_idx)
    );

    sbyp_last_set #(.N(N), .PW(PW)) u_hi (
        .vec_i   (hi_match),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    // Lower side is younger, so it takes precedence.
    always_comb begin
        hazard_o     = lo_found || hi_found;
        hazard_idx_o = lo_found ? lo_idx : (hi_found ? hi_idx : '0);
    end

    // Checks against the ports: selected slot is a real writer, nothing younger matches.
    always_comb begin
        if (hazard_o) begin
            assert_sel_is_writer_R1: assert (valid_i[hazard_idx_o]
                && (dest_fp_i[hazard_idx_o] == src_fp_i)
                && (dest_idx_i[int'(hazard_idx_o)*RW +: RW] == src_idx_i))
                else $error("selected slot is not a writer");
        end
        if (!src_fp_i && (src_idx_i == '0)) begin
            assert_int_zero_quiet_R2: assert (!hazard_o)
                else $error("hazard on integer register 0");
        end
        if (!hazard_o) begin
            assert_idle_index_R6: assert (hazard_idx_o == '0)
                else $error("index nonzero without hazard");
        end
        if (hazard_o) begin
            for (int j = 0; j < N; j++) begin
                if (valid_i[j] && (dest_fp_i[j] == src_fp_i)
                    && (dest_idx_i[j*RW +: RW] == src_idx_i)) begin
                    assert_none_younger_R4: assert (
                        ((int'(issue_ptr_i) + N - 1 - j) % N) >=
                        ((int'(issue_ptr_i) + N - 1 - int'(hazard_idx_o)) % N))
                        else $error("a younger writer was skipped");
                end
            end
        end
    end
endmodule

// File: tb/sim_sb_youngest_producer.sv
module sim_sb_youngest_producer;
    localparam int N  = 8;
    localparam int RW = 5;
    localparam int PW = $clog2(N);

    typedef struct {
        logic          hz;
        logic [PW-1:0] idx;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    valid;
    logic [N*RW-1:0] dest;
    logic [N-1:0]    dfp;
    logic [PW-1:0]   ptr;
    logic [RW-1:0]   src;
    logic            sfp;
    logic            hz;
    logic [PW-1:0]   hidx;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    sb_youngest_producer #(.N(N), .RW(RW)) u0 (
        .valid_i(valid), .dest_idx_i(dest), .dest_fp_i(dfp),
        .issue_ptr_i(ptr), .src_idx_i(src), .src_fp_i(sfp),
        .hazard_o(hz), .hazard_idx_o(hidx)
    );

    // Reference: walk backwards from the slot just below the pointer.
    function automatic exp_t ref_scan(input string tag);
        exp_t e;
        e.hz = 1'b0; e.idx = '0; e.tag = tag;
        if (!(sfp == 1'b0 && src == '0)) begin
            for (int k = 1; k <= N; k++) begin
                int j;
                j = (int'(ptr) + N - k) % N;
                if (!e.hz && valid[j] && dfp[j] == sfp && dest[j*RW +: RW] == src) begin
                    e.hz = 1'b1; e.idx = PW'(j);
                end
            end
        end
        return e;
    endfunction

    // Driver: apply one pattern after a rising edge and queue its expectation.
    task automatic drive(input logic [N-1:0] v, input logic [N*RW-1:0] d,
                         input logic [N-1:0] f, input logic [PW-1:0] p,
                         input logic [RW-1:0] s, input logic sf, input string tag);
        @(posedge clk);
        #1;
        valid = v; dest = d; dfp = f; ptr = p; src = s; sfp = sf;
        q.push_back(ref_scan(tag));
    endtask

    function automatic logic [N*RW-1:0] fill(input logic [RW-1:0] r);
        logic [N*RW-1:0] x;
        for (int k = 0; k < N; k++) x[k*RW +: RW] = r;
        return x;
    endfunction

    // Monitor: compare on the falling edge, away from the driving edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hz !== e.hz || hidx !== e.idx) begin
                errors++;
                $display("FAIL %s: got hazard=%0b idx=%0d, expected hazard=%0b idx=%0d",
                         e.tag, hz, hidx, e.hz, e.idx);
            end
        end
    end

    initial begin
        logic [N*RW-1:0] d;
        valid = '0; dest = '0; dfp = '0; ptr = '0; src = '0; sfp = 1'b0;
        // R6: empty scoreboard.
        drive('0, fill(5'd3), '0, 3'd2, 5'd3, 1'b0, "R6 empty");
        // R7: pointer 0, writers at 3 and 6.
        drive(8'b0100_1000, fill(5'd9), '0, 3'd0, 5'd9, 1'b0, "R7 ptr0");
        // R8/R4: pointer 7, writers at 2,5,7 -> 5.
        drive(8'b1010_0100, fill(5'd4), '0, 3'd7, 5'd4, 1'b0, "R8 R4 ptrN-1");
        // R8/R5: pointer 7, only slot 7 -> 7.
        drive(8'b1000_0000, fill(5'd4), '0, 3'd7, 5'd4, 1'b0, "R8 R5 ptrN-1 upper");
        // R4: pointer 4, writers at 1,2,6 -> 2.
        drive(8'b0100_0110, fill(5'd12), '0, 3'd4, 5'd12, 1'b0, "R4 both sides");
        // R5: pointer 4, writers at 5,7 -> 7.
        drive(8'b1010_0000, fill(5'd12), '0, 3'd4, 5'd12, 1'b0, "R5 upper only");
        // R5: pointer 4, writer exactly at pointer slot.
        drive(8'b0001_0000, fill(5'd12), '0, 3'd4, 5'd12, 1'b0, "R5 at pointer");
        // R2: integer register 0 with valid integer writers.
        drive('1, fill(5'd0), '0, 3'd3, 5'd0, 1'b0, "R2 int x0");
        // R2: floating-point register 0 is a normal register.
        drive(8'b0000_1010, fill(5'd0), '1, 3'd3, 5'd0, 1'b1, "R2 fp r0");
        // R1: file flag mismatch.
        drive('1, fill(5'd7), '1, 3'd5, 5'd7, 1'b0, "R1 file mismatch");
        // R1: matching index but not valid.
        drive('0, fill(5'd7), '0, 3'd5, 5'd7, 1'b0, "R1 invalid slot");
        // R1: valid slots, different registers except slot 6.
        d = fill(5'd1); d[6*RW +: RW] = 5'd20;
        drive('1, d, '0, 3'd2, 5'd20, 1'b0, "R1 single index");
        // R3: random contents with a small register range to force repeats.
        for (int t = 0; t < 400; t++) begin
            logic [N*RW-1:0] rd;
            for (int k = 0; k < N; k++) rd[k*RW +: RW] = RW'($urandom_range(0, 3));
            drive(N'($urandom), rd, N'($urandom), PW'($urandom),
                  RW'($urandom_range(0, 3)), 1'($urandom), "R3 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule